// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A starting address is captured whenever either of two active-low address strobes is low: one strobe serves a processor-side master and one serves a cache-controller-side master. The bits above bit 1 are held from that capture for the rest of the burst. The two low bits are generated from the captured start value and a two-bit beat index.

The beat index moves forward by one on each clock in which the active-low advance input is low. A mode input picks the order of the low bits. When the mode is high the order is interleaved: the start value XOR the beat index. When the mode is low the order is linear: the start value plus the beat index, modulo 4. After the fourth beat the index wraps, so the next advance returns to the start address and the cycle repeats.

Top module: `bseq_top`

## Requirements
- R1: A synchronous active-high `rst` clears the beat index and the held address, so `beat` reads 0 and `addr_out` reads 0 after the reset edge.
- R2: At a clock edge where `strobe_cpu_n` or `strobe_ctl_n` (or both) is low, the block captures `addr_in` and sets `beat` to 0. From the next cycle `addr_out` equals the captured `addr_in`.
- R3: A strobe wins over an advance asserted in the same cycle. The burst restarts at beat 0 and does not step.
- R4: With both strobes high and `adv_n` high, `beat` and `addr_out` keep their values, provided `interleave` is unchanged.
- R5: With both strobes high and `adv_n` low, `beat` goes up by one, modulo 4.
- R6: With `interleave` = 1, `addr_out[1:0]` equals the captured start bits XOR `beat`. For example, start 01 gives 01, 00, 11, 10.
- R7: With `interleave` = 0, `addr_out[1:0]` equals the captured start bits plus `beat`, modulo 4. For example, start 10 gives 10, 11, 00, 01.
- R8: An advance from beat 3 returns `beat` to 0 and `addr_out` to the captured start address. Further advances repeat the same four-beat order.
- R9: `addr_out[ADDR_W-1:2]` changes only on a load. A wrap of the low two bits never carries into them.
- R10: `interleave` acts on `addr_out[1:0]` combinationally and leaves `beat` alone, so changing the mode during a burst reorders the current address at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Start address bus |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_out | output | ADDR_W | Current beat address |
| beat | output | 2 | Beat index within the burst |

## Verification
The hold and linear-step properties assume that `interleave` does not change between the two edges they compare. They tolerate a mode change by checking the low bits only when the mode is steady. The reference bench drives `interleave` only at the falling edge. Its mode changes in the middle of a burst are checked immediately at the outputs and are not relied on across an edge. Any mix of strobes and advance is legal input, so the random phase draws all three freely, with reset applied only at known points.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
   localparam int unsigned LOW_W = 2;
   localparam int unsigned BEATS = 1 << LOW_W;
   typedef logic [LOW_W-1:0] beat_t;
   typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl (
   input  logic strobe_cpu_n,
   input  logic strobe_ctl_n,
   input  logic adv_n,
   output logic load,
   output logic step
);
   // a strobe on either side starts a burst and masks any advance
   always_comb begin
      load = ~strobe_cpu_n | ~strobe_ctl_n;
      step = ~load & ~adv_n;
   end
endmodule

// File: rtl/bseq_beat.sv
module bseq_beat
   import bseq_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  load,
   input  logic  step,
   output beat_t beat_q
);
   always_ff @(posedge clk) begin
      if (rst)       beat_q <= '0;
      else if (load) beat_q <= '0;
      else if (step) beat_q <= beat_q + beat_t'(1);  // wraps after the last beat
   end
endmodule

// File: rtl/bseq_base.sv
module bseq_base #(
   parameter int unsigned ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_q
);
   always_ff @(posedge clk) begin
      if (rst)       base_q <= '0;
      else if (load) base_q <= addr_in;
   end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
   import bseq_pkg::*;
(
   input  beat_t  start,
   input  beat_t  beat,
   input  order_e mode,
   output beat_t  low
);
   always_comb begin
      unique case (mode)
         ORD_INTERLEAVE: low = start ^ beat;
         default:        low = start + beat;
      endcase
   end
endmodule

// File: rtl/bseq_top.sv
module bseq_top
   import bseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              adv_n,
   input  logic              interleave,
   output logic [ADDR_W-1:0] addr_out,
   output logic [LOW_W-1:0]  beat
);
   localparam int unsigned UP_W = ADDR_W - LOW_W;

   generate
      if (ADDR_W <= LOW_W) begin : g_bad_width
         $error("bseq_top: ADDR_W must exceed the two sequenced bits");
      end
   endgenerate

   logic              load, step;
   beat_t             beat_q, low;
   logic [ADDR_W-1:0] base_q;
   order_e            mode;

   assign mode = order_e'(interleave);

   bseq_ctrl u_ctrl (
      .strobe_cpu_n (strobe_cpu_n),
      .strobe_ctl_n (strobe_ctl_n),
      .adv_n        (adv_n),
      .load         (load),
      .step         (step)
   );

   bseq_beat u_beat (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .step   (step),
      .beat_q (beat_q)
   );

   bseq_base #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .addr_in (addr_in),
      .base_q  (base_q)
   );

   bseq_order u_order (
      .start (base_q[LOW_W-1:0]),
      .beat  (beat_q),
      .mode  (mode),
      .low   (low)
   );

   // upper bits come only from the held base: no carry out of the counter
   assign addr_out = {base_q[ADDR_W-1 -: UP_W], low};
   assign beat     = beat_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
   parameter int unsigned ADDR_W = 19
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr_in,
   input logic              strobe_cpu_n,
   input logic              strobe_ctl_n,
   input logic              adv_n,
   input logic              interleave,
   input logic [ADDR_W-1:0] addr_out,
   input logic [1:0]        beat
);
   logic ld;
   assign ld = !strobe_cpu_n || !strobe_ctl_n;

   p_load_addr_r2: assert property (@(posedge clk) disable iff (rst)
      ld |=> (addr_out == $past(addr_in)) && (beat == 2'd0));

   p_strobe_wins_r3: assert property (@(posedge clk) disable iff (rst)
      (ld && !adv_n) |=> beat == 2'd0);

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!ld && adv_n) |=> $stable(beat) && (!$stable(interleave) || $stable(addr_out)));

   p_step_r5: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n) |=> beat == ($past(beat) + 2'd1));

   p_linear_r7: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n && !interleave) |=>
         (interleave || addr_out[1:0] == ($past(addr_out[1:0]) + 2'd1)));

   p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
      (!ld && !adv_n && beat == 2'd3) |=> beat == 2'd0);

   p_upper_r9: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(addr_out[ADDR_W-1:2]));
endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .addr_in      (addr_in),
   .strobe_cpu_n (strobe_cpu_n),
   .strobe_ctl_n (strobe_ctl_n),
   .adv_n        (adv_n),
   .interleave   (interleave),
   .addr_out     (addr_out),
   .beat         (beat)
);

// File: tb/sim_bseq_top.sv
module sim_bseq_top;
   localparam int W = 19;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] addr_in = '0;
   logic         s_cpu_n = 1'b1, s_ctl_n = 1'b1, adv_n = 1'b1, il = 1'b0;
   logic [W-1:0] addr_out;
   logic [1:0]   beat;

   int n_chk = 0, n_bad = 0;
   int m_up = 0, m_start = 0, m_beat = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bseq_top #(.ADDR_W(W)) u0 (
      .clk (clk), .rst (rst), .addr_in (addr_in),
      .strobe_cpu_n (s_cpu_n), .strobe_ctl_n (s_ctl_n),
      .adv_n (adv_n), .interleave (il),
      .addr_out (addr_out), .beat (beat)
   );

   function automatic int exp_low();
      return il ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
   endfunction

   task automatic compare(input string tag);
      int exp_a;
      exp_a = (m_up << 2) | exp_low();
      n_chk++;
      if (beat !== 2'(m_beat) || addr_out !== W'(exp_a)) begin
         n_bad++;
         $display("FAIL %s: addr=%h beat=%0d, expected addr=%h beat=%0d",
                  tag, addr_out, beat, W'(exp_a), m_beat);
      end
   endtask

   task automatic cyc(input bit r, input bit sc, input bit sk, input bit av,
                      input bit mode, input logic [W-1:0] a);
      string tag;
      bit    ld;
      @(negedge clk);
      rst = r; s_cpu_n = sc; s_ctl_n = sk; adv_n = av; il = mode; addr_in = a;
      ld = !sc || !sk;
      @(posedge clk);
      if (r)              begin m_up = 0; m_start = 0; m_beat = 0; tag = "R1"; end
      else if (ld && !av) begin m_up = int'(a >> 2); m_start = int'(a[1:0]); m_beat = 0; tag = "R3"; end
      else if (ld)        begin m_up = int'(a >> 2); m_start = int'(a[1:0]); m_beat = 0; tag = "R2"; end
      else if (av)        tag = "R4";
      else if (m_beat == 3) begin m_beat = 0; tag = "R8"; end
      else begin m_beat = m_beat + 1; tag = mode ? "R6" : "R7"; end
      #1;
      if (!r && !ld) tag = {tag, "/R5/R9"};
      compare(tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cyc(1, 1, 1, 1, 0, 19'h7ffff);
      cyc(1, 1, 1, 0, 1, 19'h12345);
      // R2/R7 linear burst from start 10, with wrap (R8) and repeat
      cyc(0, 0, 1, 1, 0, 19'h1abc6);
      for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 0, '0);
      // R6 interleaved from start 01 via controller strobe
      cyc(0, 1, 0, 1, 1, 19'h05551);
      for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 1, '1);
      // R4 hold
      for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 1, 19'h00002);
      // R3 strobe with advance in same cycle, both strobes
      cyc(0, 1, 1, 0, 1, '0);
      cyc(0, 0, 0, 0, 1, 19'h3fff3);
      // R9 linear from 11 under all-ones upper: low wraps, no carry
      cyc(0, 0, 1, 1, 0, 19'h7ffff);
      for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, '0);
      // R10 mode flipped mid-burst, observed without a clock edge
      cyc(0, 0, 1, 1, 0, 19'h00009);
      cyc(0, 1, 1, 0, 0, '0);
      @(negedge clk); il = 1'b1; #1; compare("R10");
      il = 1'b0; #1; compare("R10");
      // random mix
      for (int i = 0; i < 400; i++)
         cyc(i % 97 == 0, ($urandom % 6) != 0, ($urandom % 7) != 0,
             $urandom % 3 == 0, $urandom % 2 == 1, W'($urandom));
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule